// File: doc/BRIEF.md
# Memory CRC integrity monitor

This block guards a region of memory against silent corruption. Once its channel is enabled, each trigger pulse starts one pass. The block loads the region settings and the starting checksum, then reads the region over a synchronous read port, one beat per cycle. Every byte it reads goes into a reflected CRC engine. The image is expected to carry its own check value in its last bytes, so the pass ends by comparing the accumulated checksum with a fixed residue. No CRC is ever output.

A good image raises the complete flag, and the channel stays armed for the next trigger. A bad image raises the CRC-error bit and the transfer-error flag, and the channel shuts itself off until software enables it again. Both flags are sticky and are cleared by write-one pulses. Each flag drives an interrupt line through its own enable.

Top module: `mem_crc_monitor`

## Requirements
- R1: After reset, the channel is disabled, all flags and interrupt lines are 0, and no read is issued.
- R2: The block reads only while the channel is enabled. A trigger to an enabled, idle channel samples the settings and loads the checksum. The block then issues exactly `cfg_beats` reads, the first one at `cfg_src`.
- R3: The checksum is a reflected CRC with no final XOR. CRC-16 uses polynomial 0x1021 and CRC-32 uses 0x04C11DB7. In 16-bit mode only `cfg_init[15:0]` is used. Bytes enter in increasing address order, and the byte at the lowest address of a beat sits on `mem_rd_data[7:0]`. Read data is valid one cycle after `mem_rd_en`.
- R4: In CRC-16 mode (`cfg_crc32`=0) a pass succeeds only if the final checksum is 0x0000. The last two bytes hold the check value, low byte first. With word beats, two zero bytes come before them in the last word.
- R5: In CRC-32 mode (`cfg_crc32`=1) a pass succeeds only if the final checksum equals 0x2144DF1C. The last four bytes of the image hold the check value.
- R6: A failed pass clears `ch_enabled` and sets both `crc_err` and `terr_flag`. `irq_terr` is high only while `terr_flag` and `ie_terr` are both 1. A `ch_en_set` pulse enables the channel again.
- R7: A successful pass sets `tcmpl_flag` and leaves the channel enabled. `irq_tcmpl` is high only while `tcmpl_flag` and `ie_tcmpl` are both 1. The next trigger starts a new pass from a freshly loaded checksum.
- R8: A trigger has no effect while a pass is running or while the channel is disabled.
- R9: `crc_err`, `terr_flag` and `tcmpl_flag` stay set until their clear input (`clr_crc_err`, `clr_terr`, `clr_tcmpl`) is pulsed. Each clear input affects only its own flag.
- R10: A beat count of 0 ends the pass with no read. The comparison is then made on the initial checksum.
- R11: `cfg_beat` selects the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Each beat adds that many bytes to the CRC, and each read address is the previous one plus the beat size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_crc32 | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| cfg_beat | input | 2 | Beat size code |
| cfg_src | input | AW | Byte address of the region start |
| cfg_beats | input | CW | Number of beats per pass |
| cfg_init | input | 32 | Initial checksum value |
| ch_en_set | input | 1 | Pulse that enables the channel |
| trigger | input | 1 | Pulse that starts a pass |
| ie_terr | input | 1 | Transfer-error interrupt enable |
| ie_tcmpl | input | 1 | Transfer-complete interrupt enable |
| clr_crc_err | input | 1 | Write-one clear of `crc_err` |
| clr_terr | input | 1 | Write-one clear of `terr_flag` |
| clr_tcmpl | input | 1 | Write-one clear of `tcmpl_flag` |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | AW | Byte address of the beat |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| ch_enabled | output | 1 | Channel-enable state |
| crc_err | output | 1 | Sticky CRC mismatch status |
| terr_flag | output | 1 | Sticky transfer-error flag |
| tcmpl_flag | output | 1 | Sticky transfer-complete flag |
| irq_terr | output | 1 | Transfer-error interrupt request |
| irq_tcmpl | output | 1 | Transfer-complete interrupt request |

## Verification
Intact images are built for every pairing of polynomial and beat size. Each one must pass, which shows that byte order, lane order, padding and residue agree with the engine. Images with a single flipped bit must fail in both modes, which shows that the comparison does not pass by default. The read count and the address stride tell the three beat sizes apart. Zero-length passes with chosen initial values, a repeated trigger on the same image, triggers sent mid-pass or while disabled, and separate clear pulses probe the loading, rearming and sticky behaviour.

// File: rtl/mem_crc_monitor.sv
module mem_crc_monitor #(
  parameter int AW = 16,
  parameter int CW = 12
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_crc32,
  input  logic [1:0]    cfg_beat,
  input  logic [AW-1:0] cfg_src,
  input  logic [CW-1:0] cfg_beats,
  input  logic [31:0]   cfg_init,
  input  logic          ch_en_set,
  input  logic          trigger,
  input  logic          ie_terr,
  input  logic          ie_tcmpl,
  input  logic          clr_crc_err,
  input  logic          clr_terr,
  input  logic          clr_tcmpl,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          ch_enabled,
  output logic          crc_err,
  output logic          terr_flag,
  output logic          tcmpl_flag,
  output logic          irq_terr,
  output logic          irq_tcmpl
);
  localparam logic [31:0] RESIDUE32   = 32'h2144DF1C;
  localparam logic [31:0] POLY32_REFL = 32'hEDB88320;
  localparam logic [31:0] POLY16_REFL = 32'h00008408;

  typedef enum logic [2:0] {IDLE, LOAD, READ, CHECK, DONE, ERROR} state_t;

  state_t        st;
  logic          en_q, w32_q, pend_q;
  logic [1:0]    bsz_q;
  logic [31:0]   crc_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] iss_q, rcv_q;
  logic          crc_err_q, terr_q, tcmpl_q;
  logic [2:0]    nbytes;
  logic          match;

  function automatic logic [31:0] crc_beat(input logic [31:0] c, input logic [31:0] d,
                                           input logic [2:0] n, input logic w);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) begin
        r[7:0] = r[7:0] ^ d[8*i +: 8];
        for (int b = 0; b < 8; b++)
          r = r[0] ? ((r >> 1) ^ (w ? POLY32_REFL : POLY16_REFL)) : (r >> 1);
      end
    end
    return r;
  endfunction

  assign nbytes      = (bsz_q == 2'd0) ? 3'd1 : (bsz_q == 2'd1) ? 3'd2 : 3'd4;
  assign match       = w32_q ? (crc_q == RESIDUE32) : (crc_q[15:0] == 16'h0000);
  assign mem_rd_en   = (st == READ) && (iss_q != '0);
  assign mem_rd_addr = addr_q;
  assign ch_enabled  = en_q;
  assign crc_err     = crc_err_q;
  assign terr_flag   = terr_q;
  assign tcmpl_flag  = tcmpl_q;
  assign irq_terr    = terr_q & ie_terr;
  assign irq_tcmpl   = tcmpl_q & ie_tcmpl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      en_q      <= 1'b0;
      w32_q     <= 1'b0;
      bsz_q     <= 2'd0;
      crc_q     <= '0;
      addr_q    <= '0;
      iss_q     <= '0;
      rcv_q     <= '0;
      pend_q    <= 1'b0;
      crc_err_q <= 1'b0;
      terr_q    <= 1'b0;
      tcmpl_q   <= 1'b0;
    end else begin
      pend_q    <= mem_rd_en;
      crc_err_q <= (st == ERROR) | (crc_err_q & ~clr_crc_err);
      terr_q    <= (st == ERROR) | (terr_q & ~clr_terr);
      tcmpl_q   <= (st == DONE)  | (tcmpl_q & ~clr_tcmpl);
      case (st)
        IDLE: begin
          if (!en_q && ch_en_set) en_q <= 1'b1;
          else if (en_q && trigger) st <= LOAD;
        end
        LOAD: begin
          crc_q  <= cfg_crc32 ? cfg_init : {16'h0000, cfg_init[15:0]};
          w32_q  <= cfg_crc32;
          bsz_q  <= cfg_beat;
          addr_q <= cfg_src;
          iss_q  <= cfg_beats;
          rcv_q  <= cfg_beats;
          st     <= (cfg_beats == '0) ? CHECK : READ;
        end
        READ: begin
          if (mem_rd_en) begin
            addr_q <= addr_q + AW'(nbytes);
            iss_q  <= iss_q - 1'b1;
          end
          if (pend_q) begin
            crc_q <= crc_beat(crc_q, mem_rd_data, nbytes, w32_q);
            rcv_q <= rcv_q - 1'b1;
            if (rcv_q == CW'(1)) st <= CHECK;
          end
        end
        CHECK: st <= match ? DONE : ERROR;
        DONE:  st <= IDLE;
        ERROR: begin
          en_q <= 1'b0;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mem_crc_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd_en,
  input logic ch_enabled,
  input logic crc_err,
  input logic terr_flag,
  input logic tcmpl_flag,
  input logic clr_terr,
  input logic clr_tcmpl
);
  p_read_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ch_enabled);
  p_error_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> (!ch_enabled && terr_flag));
  p_complete_keeps_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcmpl_flag) |-> ch_enabled);
  p_terr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (terr_flag && !clr_terr) |=> terr_flag);
  p_tcmpl_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tcmpl_flag && !clr_tcmpl) |=> tcmpl_flag);
endmodule

bind mem_crc_monitor mem_crc_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .ch_enabled(ch_enabled),
  .crc_err(crc_err), .terr_flag(terr_flag), .tcmpl_flag(tcmpl_flag),
  .clr_terr(clr_terr), .clr_tcmpl(clr_tcmpl)
);

// File: tb/mem_crc_monitor_tb_top.sv
`timescale 1ns/1ps
module mem_crc_monitor_tb_top;
  logic        clk, rst_n;
  logic        cfg_crc32;
  logic [1:0]  cfg_beat;
  logic [15:0] cfg_src;
  logic [11:0] cfg_beats;
  logic [31:0] cfg_init;
  logic        ch_en_set, trigger, ie_terr, ie_tcmpl;
  logic        clr_crc_err, clr_terr, clr_tcmpl;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        ch_enabled, crc_err, terr_flag, tcmpl_flag, irq_terr, irq_tcmpl;

  mem_crc_monitor #(.AW(16), .CW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_crc32(cfg_crc32), .cfg_beat(cfg_beat),
    .cfg_src(cfg_src), .cfg_beats(cfg_beats), .cfg_init(cfg_init),
    .ch_en_set(ch_en_set), .trigger(trigger), .ie_terr(ie_terr), .ie_tcmpl(ie_tcmpl),
    .clr_crc_err(clr_crc_err), .clr_terr(clr_terr), .clr_tcmpl(clr_tcmpl),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .ch_enabled(ch_enabled), .crc_err(crc_err), .terr_flag(terr_flag),
    .tcmpl_flag(tcmpl_flag), .irq_terr(irq_terr), .irq_tcmpl(irq_tcmpl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int rd_count = 0, addr_bad = 0, exp_size = 1;
  logic [15:0] exp_base = '0;
  logic [7:0] mem [256];

  always @(posedge clk)
    if (mem_rd_en)
      mem_rd_data <= {mem[8'(mem_rd_addr + 16'd3)], mem[8'(mem_rd_addr + 16'd2)],
                      mem[8'(mem_rd_addr + 16'd1)], mem[8'(mem_rd_addr)]};

  always @(posedge clk)
    if (rst_n && mem_rd_en) begin
      if (mem_rd_addr != 16'(int'(exp_base) + rd_count * exp_size)) addr_bad++;
      rd_count++;
    end

  // {crc32, beat, corrupt, beats, seed}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 8'd6,  8'd11},
    {1'b0, 2'd1, 1'b0, 8'd5,  8'd22},
    {1'b0, 2'd2, 1'b0, 8'd4,  8'd33},
    {1'b1, 2'd0, 1'b0, 8'd9,  8'd44},
    {1'b1, 2'd1, 1'b0, 8'd6,  8'd55},
    {1'b1, 2'd2, 1'b0, 8'd5,  8'd66},
    {1'b0, 2'd0, 1'b1, 8'd6,  8'd77},
    {1'b1, 2'd2, 1'b1, 8'd4,  8'd88},
    {1'b1, 2'd1, 1'b1, 8'd3,  8'd99},
    {1'b0, 2'd2, 1'b0, 8'd1,  8'd12}
  };

  function automatic logic [31:0] m_step(logic [31:0] c, logic [7:0] b, logic w);
    logic [31:0] poly;
    poly = w ? 32'hEDB88320 : 32'h00008408;
    c[7:0] = c[7:0] ^ b;
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] m_unstep(logic [31:0] c, logic w);
    logic [31:0] poly;
    logic top;
    poly = w ? 32'hEDB88320 : 32'h00008408;
    top  = w ? c[31] : c[15];
    c = top ? (((c ^ poly) << 1) | 32'd1) : (c << 1);
    if (!w) c[31:16] = 16'h0000;
    return c;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic build_image(logic w, logic [1:0] beat, int nb, logic [7:0] seed,
                             logic [31:0] init, logic [15:0] src, logic corrupt);
    int size, total, cs;
    logic [31:0] s, t;
    logic [7:0] b;
    size  = 1 << beat;
    total = nb * size;
    cs    = w ? 4 : 2;
    s     = w ? init : {16'h0000, init[15:0]};
    for (int k = 0; k < total - cs; k++) begin
      if (!w && beat == 2'd2 && k >= total - 4) b = 8'h00;
      else b = 8'(int'(seed) * 7 + k * 29 + (k >> 2));
      mem[8'(int'(src) + k)] = b;
      s = m_step(s, b, w);
    end
    t = w ? 32'h2144DF1C : 32'h0;
    for (int j = 0; j < cs * 8; j++) t = m_unstep(t, w);
    s = s ^ t;
    for (int j = 0; j < cs; j++) mem[8'(int'(src) + total - cs + j)] = s[8*j +: 8];
    if (corrupt) mem[8'(int'(src) + 1)] = mem[8'(int'(src) + 1)] ^ 8'h08;
  endtask

  task automatic clear_flags();
    clr_crc_err = 1'b1; clr_terr = 1'b1; clr_tcmpl = 1'b1;
    tick(1);
    clr_crc_err = 1'b0; clr_terr = 1'b0; clr_tcmpl = 1'b0;
  endtask

  task automatic start_pass();
    if (!ch_enabled) begin
      ch_en_set = 1'b1; tick(1); ch_en_set = 1'b0; tick(1);
    end
    rd_count = 0; addr_bad = 0;
    trigger = 1'b1; tick(1); trigger = 1'b0;
  endtask

  task automatic wait_end(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 600; k++) begin
      if (tcmpl_flag || terr_flag) begin seen = 1'b1; break; end
      tick(1);
    end
  endtask

  task automatic set_cfg(logic w, logic [1:0] beat, int nb, logic [31:0] init, logic [15:0] src);
    cfg_crc32 = w; cfg_beat = beat; cfg_beats = 12'(nb); cfg_init = init; cfg_src = src;
    exp_base = src; exp_size = 1 << beat;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic seen;
    rst_n = 1'b0; ch_en_set = 0; trigger = 0; ie_terr = 0; ie_tcmpl = 0;
    clr_crc_err = 0; clr_terr = 0; clr_tcmpl = 0;
    mem_rd_data = '0;
    set_cfg(1'b0, 2'd0, 0, 32'h0, 16'h0);
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1", "ch_enabled", ch_enabled, 0);
    chk("R1", "flags", {crc_err, terr_flag, tcmpl_flag}, 0);
    chk("R1", "irqs", {irq_terr, irq_tcmpl}, 0);
    chk("R1", "read strobe", mem_rd_en, 0);

    // R8 trigger while disabled
    set_cfg(1'b0, 2'd0, 4, 32'h0, 16'h10);
    rd_count = 0;
    trigger = 1'b1; tick(1); trigger = 1'b0; tick(20);
    chk("R8", "reads while disabled", rd_count, 0);
    chk("R8", "flags while disabled", {terr_flag, tcmpl_flag}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      logic w, cor, ie, pass_exp;
      logic [1:0] bt;
      logic [7:0] nb, sd;
      logic [31:0] init;
      {w, bt, cor, nb, sd} = VEC[i];
      init = {sd, sd ^ 8'h5a, ~sd, sd ^ 8'hc3};
      build_image(w, bt, int'(nb), sd, init, 16'(sd), cor);
      set_cfg(w, bt, int'(nb), init, 16'(sd));
      ie = 1'(i & 1);
      ie_terr = ie; ie_tcmpl = ie;
      pass_exp = !cor;
      clear_flags();
      start_pass();
      wait_end(seen);
      tick(2);
      chk("R2", "pass finished", seen, 1);
      chk(w ? "R5/R3" : "R4/R3", "complete flag", tcmpl_flag, pass_exp);
      chk("R6", "transfer error flag", terr_flag, !pass_exp);
      chk("R6", "crc error bit", crc_err, !pass_exp);
      chk("R7/R6", "channel enable", ch_enabled, pass_exp);
      chk("R2", "read count", rd_count, nb);
      chk("R11", "address stride errors", addr_bad, 0);
      chk("R7", "irq_tcmpl", irq_tcmpl, pass_exp & ie);
      chk("R6", "irq_terr", irq_terr, !pass_exp & ie);
    end

    // R10 zero beats
    ie_terr = 1'b0; ie_tcmpl = 1'b0;
    set_cfg(1'b0, 2'd0, 0, 32'h0, 16'h0);
    clear_flags(); start_pass(); wait_end(seen); tick(1);
    chk("R10", "zero beats, init 0, crc16 passes", tcmpl_flag, 1);
    chk("R10", "zero beats reads", rd_count, 0);
    set_cfg(1'b0, 2'd0, 0, 32'h0000_1234, 16'h0);
    clear_flags(); start_pass(); wait_end(seen); tick(1);
    chk("R10", "zero beats, nonzero init fails", terr_flag, 1);
    set_cfg(1'b1, 2'd0, 0, 32'h2144DF1C, 16'h0);
    clear_flags(); start_pass(); wait_end(seen); tick(1);
    chk("R10", "zero beats, residue init crc32 passes", tcmpl_flag, 1);

    // R7 rearm: same image twice, checksum reloaded
    build_image(1'b1, 2'd1, 7, 8'd40, 32'hFFFF_FFFF, 16'h40, 1'b0);
    set_cfg(1'b1, 2'd1, 7, 32'hFFFF_FFFF, 16'h40);
    clear_flags(); start_pass(); wait_end(seen); tick(2);
    chk("R7", "first pass ok", tcmpl_flag, 1);
    clear_flags();
    chk("R7", "still enabled before retrigger", ch_enabled, 1);
    start_pass(); wait_end(seen); tick(2);
    chk("R7", "second pass ok", tcmpl_flag, 1);
    chk("R7", "second pass reads", rd_count, 7);

    // R8 trigger during pass
    build_image(1'b1, 2'd0, 20, 8'd5, 32'h0, 16'h80, 1'b0);
    set_cfg(1'b1, 2'd0, 20, 32'h0, 16'h80);
    clear_flags(); start_pass(); tick(3);
    trigger = 1'b1; tick(1); trigger = 1'b0;
    wait_end(seen); tick(30);
    chk("R8", "mid-pass trigger reads", rd_count, 20);
    chk("R8", "mid-pass trigger result", tcmpl_flag, 1);

    // R9 sticky flags and separate clears
    build_image(1'b0, 2'd1, 4, 8'd3, 32'h0, 16'hA0, 1'b1);
    set_cfg(1'b0, 2'd1, 4, 32'h0, 16'hA0);
    clear_flags(); start_pass(); wait_end(seen); tick(20);
    chk("R9", "terr held", terr_flag, 1);
    chk("R9", "crc_err held", crc_err, 1);
    chk("R9", "tcmpl held from nothing", tcmpl_flag, 0);
    clr_terr = 1'b1; tick(1); clr_terr = 1'b0; tick(1);
    chk("R9", "terr cleared", terr_flag, 0);
    chk("R9", "crc_err kept", crc_err, 1);
    clr_crc_err = 1'b1; tick(1); clr_crc_err = 1'b0; tick(1);
    chk("R9", "crc_err cleared", crc_err, 0);
    chk("R6", "disabled after error", ch_enabled, 0);
    ch_en_set = 1'b1; tick(1); ch_en_set = 1'b0; tick(1);
    chk("R6", "re-enabled", ch_enabled, 1);

    summary();
    $finish;
  end
endmodule